// File: doc/BRIEF.md
# Static Branch Direction Predictor with Misprediction Recovery

This block is the fallback direction predictor in a fetch unit. It looks at a decoded branch that got no prediction from the dynamic target cache. It picks the direction from the sign of the branch offset: a backward branch is guessed taken and a forward branch is guessed not taken. When the guess is taken, the block sends a fetch redirect to the branch target one cycle after the branch is presented.

For a conditional branch, the block passes the condition field and the guessed direction forward to the execute stage. It also keeps one recovery entry that holds the address of the path not chosen. Execute later reports whether the condition really passed. If that outcome disagrees with the guess, the block raises a flush one cycle later and supplies the stored address for refetch.

Only one recovery entry exists. A further eligible branch that arrives while the entry is in use is held off with a stall until the pending branch resolves. The block predicts only in the two native instruction states, never in the bytecode state, and only while both the global prediction enable and its own enable are set.

Top module: `static_dir_pred`

## Requirements
- R1: A predicted branch whose offset has its most significant bit at 1 (negative) is predicted taken. One whose offset MSB is 0 is predicted not taken.
- R2: When a branch is accepted and predicted taken, `redir_valid` is 1 in the following cycle. `redir_addr` is `br_pc` plus the sign-extended `br_off`. In every other cycle `redir_valid` is 0.
- R3: A branch is ignored (no redirect, no forward, no recovery entry) when `dyn_hit` is 1 or when `br_state` is not 2'b00 (wide state) or 2'b01 (compact state). The value 2'b10 is the bytecode state.
- R4: A branch is ignored unless both `glb_en` and `own_en` are 1.
- R5: An accepted conditional branch makes `fwd_valid` 1 in the following cycle. `fwd_cond` then equals its `br_cond`, and `fwd_taken` equals the predicted direction.
- R6: An accepted conditional branch stores a recovery address. For a taken guess this is the fall-through address: `br_pc`+4 in the wide state and `br_pc`+2 in the compact state. For a not-taken guess it is the target. When `res_valid` arrives with `res_taken` different from the guess, `flush_valid` is 1 in the next cycle with `flush_addr` set to the stored address.
- R7: A resolution that matches the guess gives no flush. A resolution with no pending entry is ignored.
- R8: An unconditional branch (`br_uncond`=1) is always predicted taken, even with a forward offset. It stores no recovery entry and gives no `fwd_valid`.
- R9: While a recovery entry is pending, an otherwise eligible branch sets `br_stall` in the same cycle and is not accepted. The entry is released by its resolution.
- R10: A branch presented in a cycle where `flush_valid` is 1 is discarded: there is no stall, no redirect and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global program-flow prediction enable |
| own_en | input | 1 | Enable for this static predictor |
| br_valid | input | 1 | A decoded branch is presented |
| br_pc | input | AW | Address of the branch |
| br_off | input | OW | Signed byte offset of the branch |
| br_cond | input | CW | Condition field of the branch |
| br_uncond | input | 1 | Branch is unconditional |
| br_state | input | 2 | Instruction state: 00 wide, 01 compact, 10 bytecode |
| dyn_hit | input | 1 | Dynamic predictor already predicted this branch |
| br_stall | output | 1 | Branch held off because a recovery entry is pending |
| redir_valid | output | 1 | Fetch redirect request |
| redir_addr | output | AW | Redirect target |
| fwd_valid | output | 1 | Condition info valid for execute |
| fwd_cond | output | CW | Condition field passed forward |
| fwd_taken | output | 1 | Direction that was predicted |
| res_valid | input | 1 | Execute reports the pending branch's outcome |
| res_taken | input | 1 | Condition actually passed |
| flush_valid | output | 1 | Misprediction flush and refetch request |
| flush_addr | output | AW | Refetch address |

## Verification
The bench checks the sign boundary in both directions, because a design that swaps the rule redirects forward branches and lets loops fall through. It checks the compact state's fall-through of pc+2, which a design with a fixed 4-byte step would get wrong on every compact mispredict. It checks forward-offset unconditional branches, which a purely sign-based design would not redirect. It also checks that a second branch stalls while an entry is pending, and that branches in a flush cycle are dropped. A design that got the stall wrong would overwrite the first recovery address, and one that missed the drop would redirect onto a wrong path.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [1:0] {
        ISA_WIDE    = 2'b00,
        ISA_COMPACT = 2'b01,
        ISA_BYTE    = 2'b10,
        ISA_RSVD    = 2'b11
    } isa_e;

    localparam int WIDE_STEP    = 4;
    localparam int COMPACT_STEP = 2;

    function automatic logic isa_native(input isa_e s);
        return (s == ISA_WIDE) || (s == ISA_COMPACT);
    endfunction

endpackage

// File: rtl/sdp_addr_calc.sv
module sdp_addr_calc
    import sdp_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 24
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] off,
    input  isa_e          isa,
    output logic [AW-1:0] target,
    output logic [AW-1:0] fallthru
);
    localparam int EXT = AW - OW;

    logic [AW-1:0] off_ext;
    logic [AW-1:0] step;

    generate
        if (EXT > 0) begin : g_ext
            assign off_ext = {{EXT{off[OW-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[AW-1:0];
        end
    endgenerate

    always_comb begin
        step     = (isa == ISA_COMPACT) ? AW'(COMPACT_STEP) : AW'(WIDE_STEP);
        target   = pc + off_ext;
        fallthru = pc + step;
    end
endmodule

// File: rtl/sdp_dir_decide.sv
module sdp_dir_decide
    import sdp_pkg::*;
(
    input  logic br_valid,
    input  logic glb_en,
    input  logic own_en,
    input  logic dyn_hit,
    input  isa_e isa,
    input  logic uncond,
    input  logic off_msb,
    input  logic flush_busy,
    input  logic pend,
    output logic accept,
    output logic stall,
    output logic taken,
    output logic cond_br
);
    logic eligible;

    always_comb begin
        eligible = br_valid && glb_en && own_en && !dyn_hit
                   && isa_native(isa) && !flush_busy;
        stall    = eligible && pend;
        accept   = eligible && !pend;
        taken    = uncond || off_msb;
        cond_br  = !uncond;
    end
endmodule

// File: rtl/sdp_recovery.sv
module sdp_recovery #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_taken,
    input  logic [AW-1:0] load_addr,
    input  logic          res_valid,
    input  logic          res_taken,
    output logic          pend,
    output logic          flush_valid,
    output logic [AW-1:0] flush_addr
);
    typedef struct packed {
        logic          pend;
        logic          guess;
        logic [AW-1:0] addr;
        logic          flush;
        logic [AW-1:0] flush_addr;
    } rec_t;

    rec_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.flush = 1'b0;
        if (load) begin
            s_d.pend  = 1'b1;
            s_d.guess = load_taken;
            s_d.addr  = load_addr;
        end else if (res_valid && s_q.pend) begin
            s_d.pend = 1'b0;
            if (res_taken != s_q.guess) begin
                s_d.flush      = 1'b1;
                s_d.flush_addr = s_q.addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend        = s_q.pend;
    assign flush_valid = s_q.flush;
    assign flush_addr  = s_q.flush_addr;

    // R6
    flush_needs_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flush |-> $past(res_valid));

    // R9
    single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !s_q.pend);
endmodule

// File: rtl/static_dir_pred.sv
module static_dir_pred
    import sdp_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 24,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glb_en,
    input  logic          own_en,
    input  logic          br_valid,
    input  logic [AW-1:0] br_pc,
    input  logic [OW-1:0] br_off,
    input  logic [CW-1:0] br_cond,
    input  logic          br_uncond,
    input  logic [1:0]    br_state,
    input  logic          dyn_hit,
    output logic          br_stall,
    output logic          redir_valid,
    output logic [AW-1:0] redir_addr,
    output logic          fwd_valid,
    output logic [CW-1:0] fwd_cond,
    output logic          fwd_taken,
    input  logic          res_valid,
    input  logic          res_taken,
    output logic          flush_valid,
    output logic [AW-1:0] flush_addr
);
    typedef struct packed {
        logic          redir;
        logic [AW-1:0] raddr;
        logic          fwd;
        logic [CW-1:0] cond;
        logic          ftaken;
    } out_t;

    out_t o_d, o_q;

    isa_e          isa;
    logic          accept, stall, taken, cond_br, pend;
    logic [AW-1:0] target, fallthru, rec_addr;

    assign isa = isa_e'(br_state);

    sdp_addr_calc #(.AW(AW), .OW(OW)) u_addr (
        .pc(br_pc), .off(br_off), .isa(isa),
        .target(target), .fallthru(fallthru)
    );

    sdp_dir_decide u_dir (
        .br_valid(br_valid), .glb_en(glb_en), .own_en(own_en),
        .dyn_hit(dyn_hit), .isa(isa), .uncond(br_uncond),
        .off_msb(br_off[OW-1]), .flush_busy(flush_valid), .pend(pend),
        .accept(accept), .stall(stall), .taken(taken), .cond_br(cond_br)
    );

    assign rec_addr = taken ? fallthru : target;

    sdp_recovery #(.AW(AW)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .load(accept && cond_br), .load_taken(taken), .load_addr(rec_addr),
        .res_valid(res_valid), .res_taken(res_taken),
        .pend(pend), .flush_valid(flush_valid), .flush_addr(flush_addr)
    );

    always_comb begin
        o_d        = o_q;
        o_d.redir  = accept && taken;
        o_d.fwd    = accept && cond_br;
        if (accept && taken) o_d.raddr = target;
        if (accept && cond_br) begin
            o_d.cond   = br_cond;
            o_d.ftaken = taken;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign br_stall    = stall;
    assign redir_valid = o_q.redir;
    assign redir_addr  = o_q.raddr;
    assign fwd_valid   = o_q.fwd;
    assign fwd_cond    = o_q.cond;
    assign fwd_taken   = o_q.ftaken;

    // R2
    redir_after_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.redir |-> ($past(br_valid) && !$past(dyn_hit)));

    // R3
    no_bytecode_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(br_valid) && $past(br_state) == 2'b10) |-> !o_q.redir);

    // R10
    redir_flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(o_q.redir && flush_valid));

    // R9
    stall_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> pend);
endmodule

// File: tb/static_dir_pred_test.sv
module static_dir_pred_test;
    localparam int AW = 32;
    localparam int OW = 24;
    localparam int CW = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          glb_en = 0, own_en = 0;
    logic          br_valid = 0;
    logic [AW-1:0] br_pc = '0;
    logic [OW-1:0] br_off = '0;
    logic [CW-1:0] br_cond = '0;
    logic          br_uncond = 0;
    logic [1:0]    br_state = 2'b00;
    logic          dyn_hit = 0;
    logic          br_stall, redir_valid, fwd_valid, fwd_taken, flush_valid;
    logic [AW-1:0] redir_addr, flush_addr;
    logic [CW-1:0] fwd_cond;
    logic          res_valid = 0, res_taken = 0;

    int total = 0, bad = 0, cycles = 0;

    always #5 clk = ~clk;

    static_dir_pred #(.AW(AW), .OW(OW), .CW(CW)) uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // present a branch for one cycle; outputs sampled the next negedge
    task automatic send(input logic [AW-1:0] pc, input logic [OW-1:0] off,
                        input logic [CW-1:0] c, input logic u, input logic [1:0] st,
                        input logic dh);
        @(negedge clk);
        br_valid = 1; br_pc = pc; br_off = off; br_cond = c;
        br_uncond = u; br_state = st; dyn_hit = dh;
        @(negedge clk);
        br_valid = 0; br_uncond = 0; dyn_hit = 0; br_state = 2'b00;
    endtask

    task automatic resolve(input logic t);
        @(negedge clk);
        res_valid = 1; res_taken = t;
        @(negedge clk);
        res_valid = 0; res_taken = 0;
    endtask

    task automatic t_reset;
        check("R2 reset redir", redir_valid, 0);
        check("R5 reset fwd", fwd_valid, 0);
        check("R6 reset flush", flush_valid, 0);
        check("R9 reset stall", br_stall, 0);
    endtask

    task automatic t_backward_wide;
        send(32'h1000, 24'hFFFFF0, 4'h3, 0, 2'b00, 0);
        check("R1 backward taken", redir_valid, 1);
        check("R2 target", redir_addr, 32'h0FF0);
        check("R5 fwd valid", fwd_valid, 1);
        check("R5 fwd cond", fwd_cond, 4'h3);
        check("R5 fwd taken", fwd_taken, 1);
        @(negedge clk);
        check("R2 single cycle", redir_valid, 0);
        resolve(1);
        check("R7 match no flush", flush_valid, 0);
    endtask

    task automatic t_forward_mispredict;
        send(32'h2000, 24'h000040, 4'h5, 0, 2'b00, 0);
        check("R1 forward not taken", redir_valid, 0);
        check("R5 fwd taken=0", fwd_taken, 0);
        resolve(1);
        check("R6 flush on mismatch", flush_valid, 1);
        check("R6 target recovery", flush_addr, 32'h2040);
    endtask

    task automatic t_compact_mispredict;
        send(32'h3000, 24'hFFFF80, 4'h1, 0, 2'b01, 0);
        check("R2 compact target", redir_addr, 32'h2F80);
        resolve(0);
        check("R6 compact flush", flush_valid, 1);
        check("R6 fallthru +2", flush_addr, 32'h3002);
    endtask

    task automatic t_wide_fallthru;
        send(32'h4000, 24'hFFFFFC, 4'h2, 0, 2'b00, 0);
        resolve(0);
        check("R6 fallthru +4", flush_addr, 32'h4004);
    endtask

    task automatic t_suppress;
        send(32'h5000, 24'hFFFFF0, 4'h0, 0, 2'b00, 1);
        check("R3 dyn hit ignored", redir_valid | fwd_valid, 0);
        send(32'h5000, 24'hFFFFF0, 4'h0, 0, 2'b10, 0);
        check("R3 bytecode ignored", redir_valid | fwd_valid, 0);
        glb_en = 0;
        send(32'h5000, 24'hFFFFF0, 4'h0, 0, 2'b00, 0);
        check("R4 global off", redir_valid | fwd_valid, 0);
        glb_en = 1; own_en = 0;
        send(32'h5000, 24'hFFFFF0, 4'h0, 0, 2'b00, 0);
        check("R4 own off", redir_valid | fwd_valid, 0);
        own_en = 1;
        // no entry was created: a new branch is not stalled
        @(negedge clk);
        br_valid = 1; br_off = 24'h10; #1;
        check("R3 no entry left", br_stall, 0);
        br_valid = 0;
        @(negedge clk);
        resolve(1);
    endtask

    task automatic t_uncond;
        send(32'h6000, 24'h000100, 4'hE, 1, 2'b00, 0);
        check("R8 uncond taken", redir_valid, 1);
        check("R8 uncond addr", redir_addr, 32'h6100);
        check("R8 no fwd", fwd_valid, 0);
        @(negedge clk);
        br_valid = 1; br_off = 24'h10; #1;
        check("R8 no entry", br_stall, 0);
        br_valid = 0;
        @(negedge clk);
        resolve(0);
    endtask

    task automatic t_stall;
        send(32'h7000, 24'h000020, 4'h4, 0, 2'b00, 0);
        @(negedge clk);
        br_valid = 1; br_pc = 32'h7100; br_off = 24'hFFFFF8; br_uncond = 1; #1;
        check("R9 stall while pending", br_stall, 1);
        @(negedge clk);
        br_valid = 0; br_uncond = 0;
        check("R9 no redirect when stalled", redir_valid, 0);
        resolve(1);
        check("R9 first entry kept", flush_addr, 32'h7020);
        // R10: branch in flush cycle dropped
        br_valid = 1; br_pc = 32'h7200; br_off = 24'hFFFFF8; #1;
        check("R10 no stall in flush", br_stall, 0);
        @(negedge clk);
        br_valid = 0;
        check("R10 dropped", redir_valid, 0);
        resolve(1);
        check("R7 no pending ignored", flush_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1; glb_en = 1; own_en = 1;
        t_backward_wide();
        t_forward_mispredict();
        t_compact_mispredict();
        t_wide_fallthru();
        t_suppress();
        t_uncond();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule